// File: doc/BRIEF.md
# PCI Type-0 Configuration Header Register File

This block is the configuration header for a single PCI function. A configuration request port carries a dword index, write data and four byte enables. Each request is either a read or a masked write. Reads answer one cycle later on a response port. Writes return nothing and take effect at the clock edge that accepts them.

The header holds three fixed identifier words: vendor/device, class/revision and subsystem. It also holds a command register, six base address registers and an interrupt-line register. The command register keeps only its implemented bits. Each base address register has its I/O or memory kind and its raw size set by parameters, and the size is normalised to a power of two. The block drives the memory-space and I/O-space enables, the six BAR bases and the routed interrupt input number. The routed number is taken from the function's device number.

Top module: `cfg_header`

## Requirements
- R1: Dword 0x00 (byte offset 0x00) reads the vendor/device parameter, dword 0x02 (offset 0x08) reads the class/revision parameter, and dword 0x0B (offset 0x2C) reads the subsystem parameter. Writes to these offsets change nothing.
- R2: Dword 0x01 (offset 0x04) reads 0x00A00000 OR the command value. Bit 20 is also set when the capability parameter is 1. The command value is 0 after reset.
- R3: A write to dword 0x01 sets command = ((old AND NOT m) OR (data AND m)) AND 0x21F. Here m is the 32-bit mask built from the byte enables, with byte enable k covering bits 8k+7..8k.
- R4: Output mem_en equals command bit 1 and output io_en equals command bit 0. They change only on a write to dword 0x01.
- R5: Dwords 0x04..0x09 (offsets 0x10..0x24) are BAR0..BAR5. A read returns the base ORed with the type bit: 1 for an I/O BAR, 0 for a memory BAR. Bases are 0 after reset and appear on bar_base, with BARk in bits 32k+31..32k.
- R6: On a BAR write, data bits 3:0 are cleared for an I/O BAR and data bits 1:0 for a memory BAR. The merged value, (old AND NOT m) OR (data AND m), is then ANDed with NOT (length − 1).
- R7: A BAR length is the raw size raised to at least 4 for I/O or 4096 for memory, then rounded up to a power of two. A BAR with raw size 0 always reads 0 and ignores writes.
- R8: Dword 0x0F (offset 0x3C) reads 0x100 OR the 8-bit interrupt line, which is 0 after reset. A write merges data into the line under the mask of byte enable 0 only.
- R9: Dwords 0x03, 0x0A, 0x0C, 0x0E (offsets 0x0C, 0x28, 0x30, 0x38) and every unimplemented offset read 0. Writes to them change no readable state.
- R10: irq_route equals 16 + (dev_num mod 4).
- R11: A read request produces rsp_valid with its data exactly one cycle later and reflects all earlier writes. A write request produces no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Configuration request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_dw | input | 6 | Dword index (byte offset / 4) |
| req_wdata | input | 32 | Write data |
| req_be | input | 4 | Byte enables forming the write mask |
| dev_num | input | 5 | Device number of this function |
| rsp_valid | output | 1 | Read data valid |
| rsp_data | output | 32 | Read data |
| mem_en | output | 1 | Memory-space enable (command bit 1) |
| io_en | output | 1 | I/O-space enable (command bit 0) |
| bar_base | output | 192 | Six BAR base addresses, BAR0 lowest |
| irq_route | output | 8 | Routed interrupt input number |

## Verification
The bench aims at the BAR size corners. A 3-byte I/O BAR must become 4 bytes and a 100-byte memory BAR must become 4096 bytes. A 5000-byte BAR must round to 8192, and zero-size BARs must stay at zero. A design that skipped the minimum or the rounding would keep address bits that should read as zero. Writes of all ones and partial byte-enable writes check the command bit set and mask merging. A design that dropped the 0x21F filter, or took whole-word writes, would show stray bits in the command readback or in the enables. Writes to the ROM offset and to unimplemented offsets are followed by reads of every register, which catches a decoder that lets such writes land on a neighbouring register.

// File: rtl/cfg_hdr_pkg.sv
package cfg_hdr_pkg;

    localparam int NUM_BAR = 6;
    localparam int DW      = 32;

    localparam logic [DW-1:0] CMD_IMPL    = 32'h0000_021F;
    localparam logic [DW-1:0] STATUS_BASE = 32'h00A0_0000;
    localparam logic [DW-1:0] CAP_FLAG    = 32'h0010_0000;
    localparam logic [DW-1:0] PIN_A_WORD  = 32'h0000_0100;
    localparam int            IO_MIN_LEN  = 4;
    localparam int            MEM_MIN_LEN = 4096;

    typedef enum logic [5:0] {
        DW_IDENT  = 6'h00,
        DW_CMD    = 6'h01,
        DW_CLASS  = 6'h02,
        DW_BAR0   = 6'h04,
        DW_BAR5   = 6'h09,
        DW_SUBSYS = 6'h0B,
        DW_INTR   = 6'h0F
    } cfg_dw_e;

    typedef struct packed {
        logic [DW-1:0] data;
        logic [DW-1:0] mask;
    } cfg_wr_t;

    function automatic logic [DW-1:0] be_to_mask(input logic [3:0] be);
        logic [DW-1:0] m;
        for (int k = 0; k < 4; k++) begin
            m[8*k +: 8] = {8{be[k]}};
        end
        return m;
    endfunction

    function automatic logic [DW-1:0] merge(input logic [DW-1:0] old_v,
                                            input cfg_wr_t     w);
        return (old_v & ~w.mask) | (w.data & w.mask);
    endfunction

    // Raw size to effective size: kind minimum, then next power of two.
    function automatic logic [DW-1:0] norm_len(input logic is_io,
                                               input logic [DW-1:0] raw);
        logic [DW-1:0] l;
        if (raw == '0) begin
            return '0;
        end
        l = raw;
        if (is_io && l < DW'(IO_MIN_LEN)) begin
            l = DW'(IO_MIN_LEN);
        end
        if (!is_io && l < DW'(MEM_MIN_LEN)) begin
            l = DW'(MEM_MIN_LEN);
        end
        l = l - 1'b1;
        l = l | (l >> 1);
        l = l | (l >> 2);
        l = l | (l >> 4);
        l = l | (l >> 8);
        l = l | (l >> 16);
        return l + 1'b1;
    endfunction

    function automatic logic [DW-1:0] low_clear(input logic is_io);
        return is_io ? 32'hFFFF_FFF0 : 32'hFFFF_FFFC;
    endfunction

endpackage

// File: rtl/cfg_cmd_reg.sv
module cfg_cmd_reg
    import cfg_hdr_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  cfg_wr_t       wr,
    output logic [DW-1:0] cmd_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q <= '0;
        end else if (we) begin
            cmd_q <= merge(cmd_q, wr) & CMD_IMPL;
        end
    end
endmodule

// File: rtl/cfg_bar_slot.sv
module cfg_bar_slot
    import cfg_hdr_pkg::*;
#(
    parameter logic          IS_IO   = 1'b0,
    parameter logic [31:0]   RAW_LEN = 32'd4096
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  cfg_wr_t       wr,
    output logic [DW-1:0] base_q,
    output logic [DW-1:0] rd_word
);
    localparam logic [DW-1:0] LEN      = norm_len(IS_IO, RAW_LEN);
    localparam logic          PRESENT  = (LEN != '0);
    localparam logic [DW-1:0] ALIGN    = PRESENT ? ~(LEN - 1'b1) : '0;
    localparam logic [DW-1:0] TYPE_BIT = {{(DW-1){1'b0}}, IS_IO};

    cfg_wr_t wr_clr;

    always_comb begin
        wr_clr      = wr;
        wr_clr.data = wr.data & low_clear(IS_IO);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
        end else if (we && PRESENT) begin
            base_q <= merge(base_q, wr_clr) & ALIGN;
        end
    end

    assign rd_word = PRESENT ? (base_q | TYPE_BIT) : '0;
endmodule

// File: rtl/cfg_irq_unit.sv
module cfg_irq_unit
    import cfg_hdr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       we,
    input  cfg_wr_t    wr,
    input  logic [4:0] dev_num,
    output logic [7:0] line_q,
    output logic [7:0] route
);
    logic [DW-1:0] merged;

    assign merged = merge({24'h0, line_q}, wr);

    always_ff @(posedge clk) begin
        if (rst) begin
            line_q <= '0;
        end else if (we) begin
            line_q <= merged[7:0];
        end
    end

    assign route = 8'd16 + {3'b000, dev_num % 5'd4};
endmodule

// File: rtl/cfg_header.sv
module cfg_header
    import cfg_hdr_pkg::*;
#(
    parameter logic [31:0]          VENDOR_DEVICE = 32'hABCD_0042,
    parameter logic [31:0]          CLASS_REV     = 32'h0200_0001,
    parameter logic [31:0]          SUBSYS        = 32'h0042_ABCD,
    parameter logic                 HAS_CAP       = 1'b1,
    parameter logic [NUM_BAR-1:0]   BAR_IO        = 6'b000101,
    parameter logic [NUM_BAR*32-1:0] BAR_LEN      = {32'd0, 32'd0, 32'd100,
                                                    32'd3, 32'd5000, 32'd32}
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   req_valid,
    input  logic                   req_write,
    input  logic [5:0]             req_dw,
    input  logic [31:0]            req_wdata,
    input  logic [3:0]             req_be,
    input  logic [4:0]             dev_num,
    output logic                   rsp_valid,
    output logic [31:0]            rsp_data,
    output logic                   mem_en,
    output logic                   io_en,
    output logic [NUM_BAR*32-1:0]  bar_base,
    output logic [7:0]             irq_route
);
    localparam logic [DW-1:0] CMD_FIXED = STATUS_BASE | (HAS_CAP ? CAP_FLAG : '0);

    cfg_wr_t       wr;
    logic          wr_fire;
    logic          cmd_we;
    logic          line_we;
    logic [DW-1:0] cmd_q;
    logic [7:0]    line_q;
    logic [DW-1:0] bar_rd [NUM_BAR];
    logic [DW-1:0] rd_mux;
    logic [5:0]    bar_off;

    assign wr.data = req_wdata;
    assign wr.mask = be_to_mask(req_be);
    assign wr_fire = req_valid && req_write;
    assign cmd_we  = wr_fire && (req_dw == DW_CMD);
    assign line_we = wr_fire && (req_dw == DW_INTR);
    assign bar_off = req_dw - DW_BAR0;

    cfg_cmd_reg u_cmd (
        .clk   (clk),
        .rst   (rst),
        .we    (cmd_we),
        .wr    (wr),
        .cmd_q (cmd_q)
    );

    for (genvar i = 0; i < NUM_BAR; i++) begin : g_bar
        logic bar_we;
        assign bar_we = wr_fire && (req_dw == 6'(DW_BAR0 + i));
        cfg_bar_slot #(
            .IS_IO   (BAR_IO[i]),
            .RAW_LEN (BAR_LEN[32*i +: 32])
        ) u_slot (
            .clk     (clk),
            .rst     (rst),
            .we      (bar_we),
            .wr      (wr),
            .base_q  (bar_base[32*i +: 32]),
            .rd_word (bar_rd[i])
        );
    end

    cfg_irq_unit u_irq (
        .clk     (clk),
        .rst     (rst),
        .we      (line_we),
        .wr      (wr),
        .dev_num (dev_num),
        .line_q  (line_q),
        .route   (irq_route)
    );

    always_comb begin
        rd_mux = '0;
        if (req_dw >= DW_BAR0 && req_dw <= DW_BAR5) begin
            rd_mux = bar_rd[bar_off[2:0]];
        end else begin
            case (req_dw)
                DW_IDENT:  rd_mux = VENDOR_DEVICE;
                DW_CMD:    rd_mux = CMD_FIXED | cmd_q;
                DW_CLASS:  rd_mux = CLASS_REV;
                DW_SUBSYS: rd_mux = SUBSYS;
                DW_INTR:   rd_mux = PIN_A_WORD | {24'h0, line_q};
                default:   rd_mux = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= req_valid && !req_write;
            if (req_valid && !req_write) begin
                rsp_data <= rd_mux;
            end
        end
    end

    assign mem_en = cmd_q[1];
    assign io_en  = cmd_q[0];
endmodule

// File: rtl/cfg_header_chk.sv
module cfg_header_chk
    import cfg_hdr_pkg::*;
#(
    parameter logic                  HAS_CAP = 1'b1,
    parameter logic [NUM_BAR-1:0]    BAR_IO  = 6'b000101,
    parameter logic [NUM_BAR*32-1:0] BAR_LEN = '0
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  req_valid,
    input logic                  req_write,
    input logic [5:0]            req_dw,
    input logic                  rsp_valid,
    input logic [31:0]           rsp_data,
    input logic                  mem_en,
    input logic                  io_en,
    input logic [NUM_BAR*32-1:0] bar_base,
    input logic [7:0]            irq_route
);
    localparam logic [15:0] HI_EXP = HAS_CAP ? 16'h00B0 : 16'h00A0;

    logic rd_req;
    assign rd_req = req_valid && !req_write;

    a_r11_read_rsp: assert property (@(posedge clk) disable iff (rst)
        rd_req |=> rsp_valid);

    a_r11_no_write_rsp: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write) |=> !rsp_valid);

    a_r2_status_hi: assert property (@(posedge clk) disable iff (rst)
        (rd_req && req_dw == 6'h01) |=>
        (rsp_data[31:16] == HI_EXP && rsp_data[15:10] == '0 && rsp_data[8:5] == '0));

    a_r4_enables_hold: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && req_write && req_dw == 6'h01) |=> ($stable(mem_en) && $stable(io_en)));

    a_r9_rsvd_zero: assert property (@(posedge clk) disable iff (rst)
        (rd_req && (req_dw == 6'h03 || req_dw == 6'h0A || req_dw == 6'h0C || req_dw == 6'h0E))
        |=> (rsp_data == '0));

    a_r8_pin_a: assert property (@(posedge clk) disable iff (rst)
        (rd_req && req_dw == 6'h0F) |=> (rsp_data[31:8] == 24'h1));

    a_r10_route_range: assert property (@(posedge clk) disable iff (rst)
        irq_route[7:2] == 6'b000100);

    for (genvar i = 0; i < NUM_BAR; i++) begin : g_chk
        localparam logic [31:0] LEN = norm_len(BAR_IO[i], BAR_LEN[32*i +: 32]);
        localparam logic [31:0] KEEP = (LEN == '0) ? '0 : ~(LEN - 1'b1);
        a_r6_bar_align: assert property (@(posedge clk) disable iff (rst)
            (bar_base[32*i +: 32] & ~KEEP) == '0);
    end
endmodule

bind cfg_header cfg_header_chk #(
    .HAS_CAP (HAS_CAP),
    .BAR_IO  (BAR_IO),
    .BAR_LEN (BAR_LEN)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_dw    (req_dw),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data),
    .mem_en    (mem_en),
    .io_en     (io_en),
    .bar_base  (bar_base),
    .irq_route (irq_route)
);

// File: tb/tb_cfg_header.sv
module tb_cfg_header;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] VD  = 32'hABCD_0042;
    localparam logic [31:0] CR  = 32'h0200_0001;
    localparam logic [31:0] SS  = 32'h0042_ABCD;
    localparam logic [5:0]  TIO = 6'b000101;
    localparam logic [191:0] TLEN = {32'd0, 32'd0, 32'd100, 32'd3, 32'd5000, 32'd32};

    logic         clk = 1'b0;
    logic         rst;
    logic         req_valid, req_write;
    logic [5:0]   req_dw;
    logic [31:0]  req_wdata;
    logic [3:0]   req_be;
    logic [4:0]   dev_num;
    logic         rsp_valid;
    logic [31:0]  rsp_data;
    logic         mem_en, io_en;
    logic [191:0] bar_base;
    logic [7:0]   irq_route;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    logic [31:0] m_cmd;
    logic [31:0] m_bar [6];
    logic [7:0]  m_line;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_header #(
        .VENDOR_DEVICE (VD), .CLASS_REV (CR), .SUBSYS (SS),
        .HAS_CAP (1'b1), .BAR_IO (TIO), .BAR_LEN (TLEN)
    ) dut (
        .clk (clk), .rst (rst), .req_valid (req_valid), .req_write (req_write),
        .req_dw (req_dw), .req_wdata (req_wdata), .req_be (req_be),
        .dev_num (dev_num), .rsp_valid (rsp_valid), .rsp_data (rsp_data),
        .mem_en (mem_en), .io_en (io_en), .bar_base (bar_base),
        .irq_route (irq_route)
    );

    function automatic logic [31:0] blen(input int i);
        logic [31:0] raw = TLEN[32*i +: 32];
        logic [31:0] mn  = TIO[i] ? 32'd4 : 32'd4096;
        logic [31:0] p   = 32'd1;
        if (raw == 0) return 0;
        if (raw < mn) raw = mn;
        while (p < raw) p = p << 1;
        return p;
    endfunction

    function automatic logic [31:0] bmask(input logic [3:0] be);
        return {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
    endfunction

    function automatic logic [31:0] exp_read(input logic [5:0] w);
        case (w)
            6'h00: return VD;
            6'h01: return 32'h00B0_0000 | m_cmd;
            6'h02: return CR;
            6'h0B: return SS;
            6'h0F: return 32'h100 | {24'h0, m_line};
            6'h04, 6'h05, 6'h06, 6'h07, 6'h08, 6'h09: begin
                int i = int'(w) - 4;
                if (blen(i) == 0) return 0;
                return m_bar[i] | {31'h0, TIO[i]};
            end
            default: return 0;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_write(input logic [5:0] w, input logic [31:0] d, input logic [3:0] be);
        logic [31:0] m = bmask(be);
        if (w == 6'h01) m_cmd = ((m_cmd & ~m) | (d & m)) & 32'h21F;
        else if (w == 6'h0F) m_line = 8'(((32'(m_line) & ~m) | (d & m)));
        else if (w >= 6'h04 && w <= 6'h09) begin
            int i = int'(w) - 4;
            logic [31:0] l = blen(i);
            logic [31:0] dc = d & (TIO[i] ? 32'hFFFF_FFF0 : 32'hFFFF_FFFC);
            if (l != 0) m_bar[i] = ((m_bar[i] & ~m) | (dc & m)) & ~(l - 1);
        end
    endtask

    task automatic do_write(input logic [5:0] w, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        req_valid = 1; req_write = 1; req_dw = w; req_wdata = d; req_be = be;
        @(negedge clk);
        req_valid = 0;
        model_write(w, d, be);
        check("R11 no response to write", {31'h0, rsp_valid}, 32'h0);
    endtask

    task automatic do_read(input string req, input logic [5:0] w);
        @(negedge clk);
        req_valid = 1; req_write = 0; req_dw = w; req_wdata = $urandom; req_be = 4'hF;
        @(negedge clk);
        req_valid = 0;
        check("R11 read response valid", {31'h0, rsp_valid}, 32'h1);
        check(req, rsp_data, exp_read(w));
    endtask

    task automatic check_outputs(input string req);
        check({req, " mem_en R4"}, {31'h0, mem_en}, {31'h0, m_cmd[1]});
        check({req, " io_en R4"}, {31'h0, io_en}, {31'h0, m_cmd[0]});
        for (int i = 0; i < 6; i++)
            check({req, " bar_base R5"}, bar_base[32*i +: 32], m_bar[i]);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        rst = 1; req_valid = 0; req_write = 0; req_dw = 0; req_wdata = 0; req_be = 0;
        dev_num = 5'd1;
        m_cmd = 0; m_line = 0;
        for (int i = 0; i < 6; i++) m_bar[i] = 0;
        repeat (3) @(negedge clk);
        rst = 0;

        // reset state
        check_outputs("reset");
        for (int w = 0; w < 17; w++) do_read("R1 R2 R5 R8 R9 reset read", 6'(w));

        // R3: command all ones, then partial mask
        do_write(6'h01, 32'hFFFF_FFFF, 4'hF);
        do_read("R3 cmd all ones", 6'h01);
        check("R3 cmd value", rsp_data, 32'h00B0_021F);
        check_outputs("R4 after cmd ones");
        do_write(6'h01, 32'h0000_0000, 4'h1);
        do_read("R3 cmd low byte cleared", 6'h01);
        check_outputs("R4 after cmd partial");
        do_write(6'h01, 32'h0000_0002, 4'h1);
        check_outputs("R4 memory only");

        // R6 R7: all ones on each BAR
        for (int i = 0; i < 6; i++) begin
            do_write(6'(4 + i), 32'hFFFF_FFFF, 4'hF);
            do_read("R6 R7 BAR all ones sizing", 6'(4 + i));
        end
        check("R7 io 3 -> 4", m_bar[2], 32'hFFFF_FFF0);
        check("R7 mem 5000 -> 8192", m_bar[1], 32'hFFFF_E000);
        check("R7 mem 100 -> 4096", m_bar[3], 32'hFFFF_F000);
        check("R7 zero BAR", bar_base[32*4 +: 32], 32'h0);
        check_outputs("R5 after BAR ones");
        do_write(6'h04, 32'h0000_1234, 4'h3);
        do_read("R6 BAR0 partial", 6'h04);

        // R8 line write under byte 0 only
        do_write(6'h0F, 32'hFFFF_FF5A, 4'hF);
        do_read("R8 line", 6'h0F);
        do_write(6'h0F, 32'h0000_00C3, 4'hE);
        do_read("R8 line masked out", 6'h0F);

        // R9 ROM and unimplemented writes ignored; R1 fixed words
        do_write(6'h0C, 32'hFFFF_FFFF, 4'hF);
        do_write(6'h20, 32'hFFFF_FFFF, 4'hF);
        do_write(6'h00, 32'h1111_1111, 4'hF);
        do_write(6'h0A, 32'hFFFF_FFFF, 4'hF);
        for (int w = 0; w < 17; w++) do_read("R1 R9 after ignored writes", 6'(w));
        do_read("R9 unimplemented", 6'h20);
        do_read("R9 high offset", 6'h3F);
        check_outputs("R9 state unchanged");

        // R10 routing
        for (int d = 0; d < 32; d += 3) begin
            @(negedge clk);
            dev_num = 5'(d);
            #1;
            check("R10 route", {24'h0, irq_route}, 32'(16 + (d % 4)));
        end

        // random mix
        for (int n = 0; n < 400; n++) begin
            logic [5:0] w = 6'($urandom_range(0, 18));
            if ($urandom_range(0, 1) == 1)
                do_write(w, $urandom, 4'($urandom));
            else
                do_read("R3 R6 R8 random read", w);
        end
        check_outputs("R4 R5 random end");

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule